// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This controller sits beside the processor of a small microcontroller and decides which of three low-power states the device enters. The states are a light sleep that only stops the core clock, a wait state that stops every clock while keeping supplies up, and a backup state that turns the regulator off. The choice follows from a handful of register-style control inputs: a keyed regulator-off request, a deep-sleep flag, a wait-mode request, a low-power select bit, a two-bit flash low-power field and a wait-for-interrupt strobe. From the state it drives the regulator enable, the core, peripheral and memory clock enables, and a flash mode code.

Each state has its own set of wake events. Wake pins are gated by two enable masks: one for the backup state and one for fast startup from the wait state. Leaving the backup state goes through a one-cycle reset phase that requests a core reset and tells the I/O banks to return to inputs with pull-ups. Leaving the wait or sleep state re-enables the clocks directly. An entry request is refused while a wake event for the target state is already pending. Entry into the wait state is held off until the master clock reports ready, and a status output shows while the controller waits for it.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the state is ACTIVE (lp_state_o = 0). Regulator and all three clock enables are 1, flash_mode_o = 11 (run), core_rst_req_o, io_pullup_rst_o and mck_wait_o are 0, and the regulator-off request is cleared.
- R2: A write (cfg_wr_i = 1) loads cfg_regoff_i into the regulator-off request only when cfg_key_i equals KEY_VAL. A write with any other key leaves the request unchanged.
- R3: From ACTIVE, when the regulator-off request and deep_sleep_i are both 1 and no enabled backup wake is pending, the next state is BACKUP (lp_state_o = 4). In BACKUP the regulator and all clocks are off.
- R4: From ACTIVE, when wait_req_i = 1, deep_sleep_i = 0, lp_sel_i = 1 and flash_lp_i is 00 (standby) or 01 (deep power-down), a wait entry starts. Field values 10 (idle) and 11 start no entry. In WAIT (lp_state_o = 3) the core, peripheral and memory clocks are off, the regulator stays on, and flash_mode_o shows the field captured at the request.
- R5: If mck_ready_i is 0 when a wait entry starts, the controller goes to WAIT_PENDING (lp_state_o = 2) with clocks still on and mck_wait_o = 1. It moves to WAIT in the cycle after it samples mck_ready_i = 1. A wait wake event in WAIT_PENDING returns it to ACTIVE.
- R6: From ACTIVE, wfi_i = 1 with lp_sel_i = 0 leads to SLEEP (lp_state_o = 1), where only the core clock is off. wfi_i with lp_sel_i = 1 has no effect.
- R7: When a backup entry and a sleep entry are requested in the same cycle, backup wins. Backup entry also outranks a wait entry.
- R8: In BACKUP, a wake pin with its bit set in bkp_pin_en_i, sm_alarm_i, rtc_alarm_i or rtt_alarm_i leads to WAKE_RESET (lp_state_o = 5) for exactly one cycle, with core_rst_req_o = 1 and io_pullup_rst_o = 1, and then to ACTIVE. The regulator-off request is cleared on this exit. usb_wake_i, irq_i and wake pins that are not enabled are ignored in BACKUP.
- R9: In WAIT, a wake pin enabled in fast_pin_en_i, rtc_alarm_i, rtt_alarm_i or usb_wake_i returns the controller to ACTIVE without a reset. irq_i and pins enabled only for backup are ignored.
- R10: In SLEEP, any bit of irq_i returns the controller to ACTIVE without a reset. Wake pins are ignored.
- R11: An entry request is refused, and the state stays ACTIVE, while a wake event that would end the target state is already present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Write strobe for the regulator-off request |
| cfg_key_i | input | KEY_W | Key that accompanies the write |
| cfg_regoff_i | input | 1 | Value written to the regulator-off request |
| deep_sleep_i | input | 1 | Deep-sleep flag from the core |
| wait_req_i | input | 1 | Wait-mode request bit |
| lp_sel_i | input | 1 | Low-power select (1 = wait, 0 = sleep on WFI) |
| flash_lp_i | input | 2 | Flash low-power field (00 standby, 01 deep power-down, 10 idle) |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| mck_ready_i | input | 1 | Master clock ready |
| wake_pin_i | input | NUM_PINS | Wake pin events |
| bkp_pin_en_i | input | NUM_PINS | Pins enabled to wake from backup |
| fast_pin_en_i | input | NUM_PINS | Pins enabled for fast startup from wait |
| sm_alarm_i | input | 1 | Supply monitor alarm |
| rtc_alarm_i | input | 1 | Calendar clock alarm |
| rtt_alarm_i | input | 1 | Real-time timer alarm |
| usb_wake_i | input | 1 | USB resume event |
| irq_i | input | NUM_IRQ | Enabled pending interrupts |
| reg_en_o | output | 1 | Core regulator enable |
| core_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| mem_clk_en_o | output | 1 | Memory clock enable |
| flash_mode_o | output | 2 | Flash mode code (11 = run) |
| core_rst_req_o | output | 1 | Core reset request on exit from backup |
| io_pullup_rst_o | output | 1 | I/O banks return to inputs with pull-ups |
| mck_wait_o | output | 1 | Wait entry held for master clock ready |
| lp_state_o | output | 3 | Current state code |

## Verification
Entry is tried with each control combination that should pick a state and with near misses: deep-sleep set without the request, a request written with a wrong key, the idle and reserved flash codes, a WFI while wait is selected, and deep-sleep together with a wait request. These cases separate the three entry conditions from one another. Each state is then offered every wake source, including sources that belong to another state and pins masked for the current state. This shows that each exit set is decoded per state, and that only the backup exit passes through the reset phase. Pending wakes at request time, a late master-clock-ready and aborts out of the pending wait, together with simultaneous backup and sleep requests, cover the blocking rule, the hold-off and the priority.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_SLEEP  = 3'd1,
        ST_WPEND  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_BACKUP = 3'd4,
        ST_WKRST  = 3'd5
    } lp_state_e;

    localparam logic [1:0] FL_STANDBY = 2'b00;
    localparam logic [1:0] FL_DEEPPD  = 2'b01;
    localparam logic [1:0] FL_IDLE    = 2'b10;
    localparam logic [1:0] FL_RUN     = 2'b11;

    typedef struct packed {
        logic to_backup;
        logic to_wait;
        logic to_sleep;
    } entry_t;

    typedef struct packed {
        lp_state_e  st;
        logic [1:0] fl;
    } fsm_regs_t;

endpackage

// File: rtl/lpm_keyreg.sv
module lpm_keyreg #(
    parameter int                KEY_W   = 8,
    parameter logic [KEY_W-1:0]  KEY_VAL = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             data_i,
    input  logic             clr_i,
    output logic             regoff_o
);

    logic regoff_d, regoff_q;

    always_comb begin
        regoff_d = regoff_q;
        if (clr_i) begin
            regoff_d = 1'b0;
        end else if (wr_i && (key_i == KEY_VAL)) begin
            regoff_d = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regoff_q <= 1'b0;
        end else begin
            regoff_q <= regoff_d;
        end
    end

    assign regoff_o = regoff_q;

endmodule

// File: rtl/lpm_wake.sv
module lpm_wake #(
    parameter int NUM_PINS = 16,
    parameter int NUM_IRQ  = 8
) (
    input  logic [NUM_PINS-1:0] wake_pin_i,
    input  logic [NUM_PINS-1:0] bkp_pin_en_i,
    input  logic [NUM_PINS-1:0] fast_pin_en_i,
    input  logic                sm_alarm_i,
    input  logic                rtc_alarm_i,
    input  logic                rtt_alarm_i,
    input  logic                usb_wake_i,
    input  logic [NUM_IRQ-1:0]  irq_i,
    output logic                bkp_wake_o,
    output logic                wait_wake_o,
    output logic                sleep_wake_o
);

    logic [NUM_PINS-1:0] bkp_hit;
    logic [NUM_PINS-1:0] fast_hit;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign bkp_hit[g]  = wake_pin_i[g] & bkp_pin_en_i[g];
        assign fast_hit[g] = wake_pin_i[g] & fast_pin_en_i[g];
    end

    // Each state listens to its own set of sources only.
    assign bkp_wake_o   = (|bkp_hit) | sm_alarm_i | rtc_alarm_i | rtt_alarm_i;
    assign wait_wake_o  = (|fast_hit) | rtc_alarm_i | rtt_alarm_i | usb_wake_i;
    assign sleep_wake_o = |irq_i;

endmodule

// File: rtl/lpm_decode.sv
module lpm_decode
    import lpm_pkg::*;
(
    input  logic       regoff_i,
    input  logic       deep_sleep_i,
    input  logic       wait_req_i,
    input  logic       lp_sel_i,
    input  logic [1:0] flash_lp_i,
    input  logic       wfi_i,
    input  logic       bkp_wake_i,
    input  logic       wait_wake_i,
    input  logic       sleep_wake_i,
    output entry_t     entry_o
);

    logic want_backup, want_wait, want_sleep, flash_ok;

    always_comb begin
        flash_ok    = (flash_lp_i == FL_STANDBY) || (flash_lp_i == FL_DEEPPD);
        want_backup = regoff_i && deep_sleep_i;
        want_wait   = wait_req_i && !deep_sleep_i && lp_sel_i && flash_ok;
        want_sleep  = wfi_i && !lp_sel_i;

        entry_o = '0;
        // The highest-ranked request decides alone; a pending wake for
        // that state blocks entry and does not fall through to a lower one.
        if (want_backup) begin
            entry_o.to_backup = !bkp_wake_i;
        end else if (want_wait) begin
            entry_o.to_wait = !wait_wake_i;
        end else if (want_sleep) begin
            entry_o.to_sleep = !sleep_wake_i;
        end
    end

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  entry_t     entry_i,
    input  logic [1:0] flash_lp_i,
    input  logic       mck_ready_i,
    input  logic       bkp_wake_i,
    input  logic       wait_wake_i,
    input  logic       sleep_wake_i,
    output lp_state_e  state_o,
    output logic       reg_en_o,
    output logic       core_clk_en_o,
    output logic       periph_clk_en_o,
    output logic       mem_clk_en_o,
    output logic [1:0] flash_mode_o,
    output logic       core_rst_req_o,
    output logic       io_pullup_rst_o,
    output logic       mck_wait_o
);

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_ACTIVE: begin
                if (entry_i.to_backup) begin
                    r_d.st = ST_BACKUP;
                end else if (entry_i.to_wait) begin
                    r_d.fl = flash_lp_i;
                    r_d.st = mck_ready_i ? ST_WAIT : ST_WPEND;
                end else if (entry_i.to_sleep) begin
                    r_d.st = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (sleep_wake_i) r_d.st = ST_ACTIVE;
            end
            ST_WPEND: begin
                if (wait_wake_i) begin
                    r_d.st = ST_ACTIVE;
                end else if (mck_ready_i) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (wait_wake_i) r_d.st = ST_ACTIVE;
            end
            ST_BACKUP: begin
                if (bkp_wake_i) r_d.st = ST_WKRST;
            end
            ST_WKRST: begin
                r_d.st = ST_ACTIVE;
            end
            default: begin
                r_d.st = ST_ACTIVE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= ST_ACTIVE;
            r_q.fl <= FL_RUN;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_en_o        = 1'b1;
        core_clk_en_o   = 1'b1;
        periph_clk_en_o = 1'b1;
        mem_clk_en_o    = 1'b1;
        flash_mode_o    = FL_RUN;
        core_rst_req_o  = 1'b0;
        io_pullup_rst_o = 1'b0;
        mck_wait_o      = 1'b0;
        unique case (r_q.st)
            ST_SLEEP: begin
                core_clk_en_o = 1'b0;
            end
            ST_WPEND: begin
                mck_wait_o = 1'b1;
            end
            ST_WAIT: begin
                core_clk_en_o   = 1'b0;
                periph_clk_en_o = 1'b0;
                mem_clk_en_o    = 1'b0;
                flash_mode_o    = r_q.fl;
            end
            ST_BACKUP: begin
                reg_en_o        = 1'b0;
                core_clk_en_o   = 1'b0;
                periph_clk_en_o = 1'b0;
                mem_clk_en_o    = 1'b0;
            end
            ST_WKRST: begin
                core_clk_en_o   = 1'b0;
                periph_clk_en_o = 1'b0;
                mem_clk_en_o    = 1'b0;
                core_rst_req_o  = 1'b1;
                io_pullup_rst_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign state_o = r_q.st;

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int               NUM_PINS = 16,
    parameter int               NUM_IRQ  = 8,
    parameter int               KEY_W    = 8,
    parameter logic [KEY_W-1:0] KEY_VAL  = 8'hA5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_i,
    input  logic [KEY_W-1:0]    cfg_key_i,
    input  logic                cfg_regoff_i,
    input  logic                deep_sleep_i,
    input  logic                wait_req_i,
    input  logic                lp_sel_i,
    input  logic [1:0]          flash_lp_i,
    input  logic                wfi_i,
    input  logic                mck_ready_i,
    input  logic [NUM_PINS-1:0] wake_pin_i,
    input  logic [NUM_PINS-1:0] bkp_pin_en_i,
    input  logic [NUM_PINS-1:0] fast_pin_en_i,
    input  logic                sm_alarm_i,
    input  logic                rtc_alarm_i,
    input  logic                rtt_alarm_i,
    input  logic                usb_wake_i,
    input  logic [NUM_IRQ-1:0]  irq_i,
    output logic                reg_en_o,
    output logic                core_clk_en_o,
    output logic                periph_clk_en_o,
    output logic                mem_clk_en_o,
    output logic [1:0]          flash_mode_o,
    output logic                core_rst_req_o,
    output logic                io_pullup_rst_o,
    output logic                mck_wait_o,
    output logic [2:0]          lp_state_o
);

    logic      regoff;
    logic      bkp_wake, wait_wake, sleep_wake;
    entry_t    entry;
    lp_state_e state;

    lpm_keyreg #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_keyreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cfg_wr_i),
        .key_i    (cfg_key_i),
        .data_i   (cfg_regoff_i),
        .clr_i    (core_rst_req_o),
        .regoff_o (regoff)
    );

    lpm_wake #(.NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ)) u_wake (
        .wake_pin_i    (wake_pin_i),
        .bkp_pin_en_i  (bkp_pin_en_i),
        .fast_pin_en_i (fast_pin_en_i),
        .sm_alarm_i    (sm_alarm_i),
        .rtc_alarm_i   (rtc_alarm_i),
        .rtt_alarm_i   (rtt_alarm_i),
        .usb_wake_i    (usb_wake_i),
        .irq_i         (irq_i),
        .bkp_wake_o    (bkp_wake),
        .wait_wake_o   (wait_wake),
        .sleep_wake_o  (sleep_wake)
    );

    lpm_decode u_decode (
        .regoff_i     (regoff),
        .deep_sleep_i (deep_sleep_i),
        .wait_req_i   (wait_req_i),
        .lp_sel_i     (lp_sel_i),
        .flash_lp_i   (flash_lp_i),
        .wfi_i        (wfi_i),
        .bkp_wake_i   (bkp_wake),
        .wait_wake_i  (wait_wake),
        .sleep_wake_i (sleep_wake),
        .entry_o      (entry)
    );

    lpm_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .entry_i         (entry),
        .flash_lp_i      (flash_lp_i),
        .mck_ready_i     (mck_ready_i),
        .bkp_wake_i      (bkp_wake),
        .wait_wake_i     (wait_wake),
        .sleep_wake_i    (sleep_wake),
        .state_o         (state),
        .reg_en_o        (reg_en_o),
        .core_clk_en_o   (core_clk_en_o),
        .periph_clk_en_o (periph_clk_en_o),
        .mem_clk_en_o    (mem_clk_en_o),
        .flash_mode_o    (flash_mode_o),
        .core_rst_req_o  (core_rst_req_o),
        .io_pullup_rst_o (io_pullup_rst_o),
        .mck_wait_o      (mck_wait_o)
    );

    assign lp_state_o = state;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
    import lpm_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         lp_state_o,
    input logic               mck_ready_i,
    input logic               deep_sleep_i,
    input logic [NUM_IRQ-1:0] irq_i,
    input logic               reg_en_o,
    input logic               core_clk_en_o,
    input logic               periph_clk_en_o,
    input logic               mem_clk_en_o,
    input logic               core_rst_req_o,
    input logic               io_pullup_rst_o
);

    assert_rst_after_backup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_req_o |-> ($past(lp_state_o) == ST_BACKUP));

    assert_rst_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_req_o |=> (!core_rst_req_o && (lp_state_o == ST_ACTIVE)));

    assert_pullup_with_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_pullup_rst_o |-> core_rst_req_o);

    assert_wait_after_mck_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((lp_state_o == ST_WAIT) && ($past(lp_state_o) != ST_WAIT)) |-> $past(mck_ready_i));

    assert_backup_after_deep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((lp_state_o == ST_BACKUP) && ($past(lp_state_o) != ST_BACKUP)) |-> $past(deep_sleep_i));

    assert_regoff_stops_clocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en_o |-> (!core_clk_en_o && !periph_clk_en_o && !mem_clk_en_o));

    assert_wait_exit_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_state_o == ST_WAIT) |=> ((lp_state_o == ST_WAIT) || (lp_state_o == ST_ACTIVE)));

    assert_sleep_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((lp_state_o == ST_ACTIVE) && (|irq_i)) |=> (lp_state_o != ST_SLEEP));

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .lp_state_o      (lp_state_o),
    .mck_ready_i     (mck_ready_i),
    .deep_sleep_i    (deep_sleep_i),
    .irq_i           (irq_i),
    .reg_en_o        (reg_en_o),
    .core_clk_en_o   (core_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .mem_clk_en_o    (mem_clk_en_o),
    .core_rst_req_o  (core_rst_req_o),
    .io_pullup_rst_o (io_pullup_rst_o)
);

// File: tb/lpm_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_ctrl_bench;

    localparam int         NP   = 16;
    localparam int         NI   = 8;
    localparam int         KW   = 8;
    localparam logic [7:0] KEYV = 8'hA5;

    // state codes as stated in the requirements
    localparam logic [2:0] SA = 3'd0, SS = 3'd1, SP = 3'd2, SW = 3'd3, SB = 3'd4, SX = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [KW-1:0] cfg_key = '0;
    logic          cfg_regoff = 1'b0;
    logic          deep = 1'b0, wreq = 1'b0, lpsel = 1'b0, wfi = 1'b0, mck = 1'b1;
    logic [1:0]    fl = 2'b00;
    logic [NP-1:0] wpin = '0;
    logic [NP-1:0] bkp_en = 16'h0001;
    logic [NP-1:0] fast_en = 16'h0008;
    logic          sm = 1'b0, rtc = 1'b0, rtt = 1'b0, usb = 1'b0;
    logic [NI-1:0] irq = '0;

    logic       reg_en, core_en, per_en, mem_en, rst_req, pu_rst, mck_wait;
    logic [1:0] fmode;
    logic [2:0] st;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lpm_ctrl #(.NUM_PINS(NP), .NUM_IRQ(NI), .KEY_W(KW), .KEY_VAL(KEYV)) u_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_key_i(cfg_key),
        .cfg_regoff_i(cfg_regoff), .deep_sleep_i(deep), .wait_req_i(wreq),
        .lp_sel_i(lpsel), .flash_lp_i(fl), .wfi_i(wfi), .mck_ready_i(mck),
        .wake_pin_i(wpin), .bkp_pin_en_i(bkp_en), .fast_pin_en_i(fast_en),
        .sm_alarm_i(sm), .rtc_alarm_i(rtc), .rtt_alarm_i(rtt), .usb_wake_i(usb),
        .irq_i(irq), .reg_en_o(reg_en), .core_clk_en_o(core_en),
        .periph_clk_en_o(per_en), .mem_clk_en_o(mem_en), .flash_mode_o(fmode),
        .core_rst_req_o(rst_req), .io_pullup_rst_o(pu_rst), .mck_wait_o(mck_wait),
        .lp_state_o(st)
    );

    typedef struct packed {
        logic       wr, kg, vr, dp, wq, ls;
        logic [1:0] fl;
        logic       wfi, mck;
        logic [3:0] wk;
        logic [2:0] st;
        logic [1:0] efl;
        logic [3:0] rq;
    } vec_t;

    function automatic vec_t mk(input logic wr, kg, vr, dp, wq, ls, input logic [1:0] f,
                                input logic w, m, input logic [3:0] wk, input logic [2:0] s,
                                input logic [1:0] ef, input logic [3:0] rq);
        return {wr, kg, vr, dp, wq, ls, f, w, m, wk, s, ef, rq};
    endfunction

    // wake codes: 1 pin0 (backup-enabled), 2 supply alarm, 3 calendar alarm, 4 timer alarm,
    // 5 usb, 6 pin3 (fast-enabled), 7 irq0, 8 pin1 (enabled nowhere)
    localparam int NV = 36;
    localparam vec_t VEC [NV] = '{
        mk(0,0,0,0,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd1),  // R1 idle
        mk(0,0,0,1,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd3),  // R3 deep alone
        mk(1,0,1,0,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd2),  // R2 wrong key
        mk(0,0,0,1,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd2),  // R2 request not set
        mk(1,1,1,0,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd2),  // R2 good key
        mk(0,0,0,1,0,0,2'b00,0,1,4'd1,SA,2'b11,4'd11), // R11 backup wake pending
        mk(0,0,0,1,0,0,2'b00,0,1,4'd0,SB,2'b11,4'd3),  // R3 enter backup
        mk(0,0,0,0,0,0,2'b00,0,1,4'd5,SB,2'b11,4'd8),  // R8 usb ignored
        mk(0,0,0,0,0,0,2'b00,0,1,4'd7,SB,2'b11,4'd8),  // R8 irq ignored
        mk(0,0,0,0,0,0,2'b00,0,1,4'd8,SB,2'b11,4'd8),  // R8 masked pin ignored
        mk(0,0,0,0,0,0,2'b00,0,1,4'd3,SX,2'b11,4'd8),  // R8 wake -> reset phase
        mk(0,0,0,0,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd8),  // R8 back to active
        mk(0,0,0,1,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd8),  // R8 request cleared
        mk(0,0,0,0,1,1,2'b00,0,1,4'd0,SW,2'b00,4'd4),  // R4 wait standby
        mk(0,0,0,0,0,0,2'b00,0,1,4'd7,SW,2'b00,4'd9),  // R9 irq ignored
        mk(0,0,0,0,0,0,2'b00,0,1,4'd1,SW,2'b00,4'd9),  // R9 backup-only pin ignored
        mk(0,0,0,0,0,0,2'b00,0,1,4'd6,SA,2'b11,4'd9),  // R9 fast pin wakes
        mk(0,0,0,0,1,1,2'b01,0,0,4'd0,SP,2'b11,4'd5),  // R5 clock not ready
        mk(0,0,0,0,0,0,2'b00,0,0,4'd0,SP,2'b11,4'd5),  // R5 still held
        mk(0,0,0,0,0,0,2'b00,0,1,4'd0,SW,2'b01,4'd5),  // R5 ready -> wait
        mk(0,0,0,0,0,0,2'b00,0,1,4'd5,SA,2'b11,4'd9),  // R9 usb wakes
        mk(0,0,0,0,1,1,2'b10,0,1,4'd0,SA,2'b11,4'd4),  // R4 idle code refused
        mk(0,0,0,1,1,1,2'b00,0,1,4'd0,SA,2'b11,4'd4),  // R4 deep blocks wait
        mk(0,0,0,0,1,1,2'b00,0,1,4'd4,SA,2'b11,4'd11), // R11 wait wake pending
        mk(0,0,0,0,0,1,2'b00,1,1,4'd0,SA,2'b11,4'd6),  // R6 wfi with wait select
        mk(0,0,0,0,0,0,2'b00,1,1,4'd0,SS,2'b11,4'd6),  // R6 enter sleep
        mk(0,0,0,0,0,0,2'b00,0,1,4'd6,SS,2'b11,4'd10), // R10 pin ignored
        mk(0,0,0,0,0,0,2'b00,0,1,4'd7,SA,2'b11,4'd10), // R10 irq wakes
        mk(0,0,0,0,0,0,2'b00,1,1,4'd7,SA,2'b11,4'd11), // R11 irq pending
        mk(1,1,1,0,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd2),  // R2 good key again
        mk(0,0,0,1,0,0,2'b00,1,1,4'd0,SB,2'b11,4'd7),  // R7 backup over sleep
        mk(0,0,0,0,0,0,2'b00,0,1,4'd2,SX,2'b11,4'd8),  // R8 supply alarm wakes
        mk(0,0,0,0,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd8),  // R8 active again
        mk(0,0,0,0,1,1,2'b00,0,0,4'd0,SP,2'b11,4'd5),  // R5 pending again
        mk(0,0,0,0,0,0,2'b00,0,0,4'd4,SA,2'b11,4'd5),  // R5 abort by timer alarm
        mk(0,0,0,0,1,1,2'b11,0,1,4'd0,SA,2'b11,4'd4)   // R4 reserved code refused
    };

    function automatic logic [11:0] expect_of(input logic [2:0] s, input logic [1:0] ef);
        logic r, c, p, m, rr, pu, mw;
        {r, c, p, m, rr, pu, mw} = 7'b1111000;
        case (s)
            SS: c = 1'b0;
            SP: mw = 1'b1;
            SW: {c, p, m} = 3'b000;
            SB: {r, c, p, m} = 4'b0000;
            SX: {c, p, m, rr, pu} = 5'b00011;
            default: ;
        endcase
        return {s, r, c, p, m, rr, pu, mw, ef};
    endfunction

    function automatic logic [11:0] got_now();
        return {st, reg_en, core_en, per_en, mem_en, rst_req, pu_rst, mck_wait, fmode};
    endfunction

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cfg_wr     = v.wr;
        cfg_key    = v.kg ? KEYV : 8'h5A;
        cfg_regoff = v.vr;
        deep = v.dp; wreq = v.wq; lpsel = v.ls; fl = v.fl; wfi = v.wfi; mck = v.mck;
        wpin = '0; sm = 1'b0; rtc = 1'b0; rtt = 1'b0; usb = 1'b0; irq = '0;
        case (v.wk)
            4'd1: wpin[0] = 1'b1;
            4'd2: sm = 1'b1;
            4'd3: rtc = 1'b1;
            4'd4: rtt = 1'b1;
            4'd5: usb = 1'b1;
            4'd6: wpin[3] = 1'b1;
            4'd7: irq[0] = 1'b1;
            4'd8: wpin[1] = 1'b1;
            default: ;
        endcase
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (all requirements)");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", got_now(), expect_of(SA, 2'b11));
        rst_n = 1'b1;
        drive(VEC[0]);
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            checks++;
            if (got_now() !== expect_of(VEC[i].st, VEC[i].efl)) begin
                fails++;
                $display("FAIL R%0d vector %0d: got %h expected %h", VEC[i].rq, i,
                         got_now(), expect_of(VEC[i].st, VEC[i].efl));
            end
        end

        // R1: reset out of WAIT, and reset clears the regulator-off request
        drive(mk(1,1,1,0,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd1)); @(negedge clk);
        drive(mk(0,0,0,0,1,1,2'b01,0,1,4'd0,SW,2'b01,4'd1)); @(negedge clk);
        check("R4 wait deep power-down", got_now(), expect_of(SW, 2'b01));
        rst_n = 1'b0;
        #1;
        check("R1 async reset from wait", got_now(), expect_of(SA, 2'b11));
        @(negedge clk);
        rst_n = 1'b1;
        drive(mk(0,0,0,1,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd1)); @(negedge clk);
        check("R1 request cleared by reset", got_now(), expect_of(SA, 2'b11));

        // R2: a keyed write of 0 withdraws the request
        drive(mk(1,1,1,0,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd2)); @(negedge clk);
        drive(mk(1,1,0,0,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd2)); @(negedge clk);
        drive(mk(0,0,0,1,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd2)); @(negedge clk);
        check("R2 keyed clear", got_now(), expect_of(SA, 2'b11));

        // R7: backup outranks a simultaneous wait request
        drive(mk(1,1,1,0,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd7)); @(negedge clk);
        drive(mk(0,0,0,1,1,1,2'b00,0,1,4'd0,SB,2'b11,4'd7)); @(negedge clk);
        check("R7 backup over wait", got_now(), expect_of(SB, 2'b11));
        drive(mk(0,0,0,0,0,0,2'b00,0,1,4'd4,SX,2'b11,4'd8)); @(negedge clk);
        check("R8 timer alarm wakes backup", got_now(), expect_of(SX, 2'b11));
        drive(mk(0,0,0,0,0,0,2'b00,0,1,4'd0,SA,2'b11,4'd8)); @(negedge clk);
        check("R8 active after reset phase", got_now(), expect_of(SA, 2'b11));

        finish_run();
    end

endmodule